// File: doc/BRIEF.md
# Serial Line Receiver with Line Status

This block recovers asynchronous serial characters from a single input line and keeps a line-status word beside the received character. The line is brought into the clock domain through a two-stage synchronizer and examined on every pulse of an externally supplied 16x oversampling tick. A falling edge starts a frame. The start bit is confirmed at mid-bit. Data bits then arrive least significant first and are followed by an optional parity bit and a stop bit. The character length (5 to 8 bits), parity enable, parity sense and the forced ("stick") parity mode come in as static format inputs.

The status word holds data ready, overrun, parity error, framing error, break and a both-empty indication. The both-empty indication combines the receive holding register with an externally supplied transmitter-empty input. A read strobe for the data register clears data ready. A read strobe for the status register clears the four error flags. A line that stays low longer than the longest possible frame is reported as a break. After a frame that ends with a low stop bit, or after a break, the receiver waits for the line to return high before it accepts another start bit.

Top module: `uart_lsr_rx`

## Requirements
- R1: The serial input passes through two synchronizer flops. A start bit is detected on an oversample tick that sees the synchronized line low while the receiver is idle. The start bit is accepted only if the line is still low on the 8th tick after that detection tick. Otherwise the receiver returns to idle and loads nothing.
- R2: After an accepted start bit, each data bit is sampled every 16 ticks, least significant bit first. The bit count is `5 + wlen_i` (0 = 5 bits, 3 = 8 bits). `rx_data_o` holds the character right-justified, with unused upper bits at 0, and changes only when a frame is loaded.
- R3: `data_ready_o` goes to 1 when a frame is loaded and goes to 0 on `rd_data_i`. When both happen in the same cycle, the load wins.
- R4: `overrun_o` goes to 1 when a frame is loaded while `data_ready_o` is 1 and `rd_data_i` is not asserted in that cycle. It goes to 0 on `rd_stat_i`, and setting wins over clearing.
- R5: With `par_en_i` = 1, a parity bit follows the data. The expected value is the XOR of the data bits for even sense (`par_even_i` = 1) and its inverse for odd sense. Under stick parity (`par_stick_i` = 1) the expected value is `par_even_i` itself. A mismatch sets `parity_err_o` at the load. It goes to 0 on `rd_stat_i`.
- R6: Only the first stop bit is sampled. If it is low, `framing_err_o` is set at the load (cleared on `rd_stat_i`), and no new start bit is accepted until the line has been seen high.
- R7: `break_o` is set once the synchronized line has stayed low for 192 consecutive ticks, which is 16 times the longest frame of 12 bits. It goes to 0 on `rd_stat_i`.
- R8: `both_empty_o` is 1 exactly when `tx_empty_i` is 1 and `data_ready_o` is 0.
- R9: After reset every status flag is 0 and `rx_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial input line, idle high |
| os_tick_i | input | 1 | 16x oversampling tick, one cycle wide |
| wlen_i | input | 2 | Character length minus 5 |
| par_en_i | input | 1 | Parity bit present and checked |
| par_even_i | input | 1 | Even parity sense; forced value under stick parity |
| par_stick_i | input | 1 | Stick (forced) parity mode |
| rd_data_i | input | 1 | Read strobe of the data register |
| rd_stat_i | input | 1 | Read strobe of the status register |
| tx_empty_i | input | 1 | Transmit holding register empty |
| rx_data_o | output | 8 | Received character, right-justified |
| data_ready_o | output | 1 | Unread character present |
| overrun_o | output | 1 | Unread character was overwritten |
| parity_err_o | output | 1 | Parity mismatch seen |
| framing_err_o | output | 1 | Low stop bit seen |
| break_o | output | 1 | Line held low past the longest frame |
| both_empty_o | output | 1 | Transmit and receive registers both empty |

## Verification
The receiver is driven with 8-bit frames without parity and with 5-, 6- and 7-bit frames with even, odd and both stick parity senses. Correct and corrupted parity bits separate the parity-sense logic from the bit-count logic. Back-to-back unread frames separate overrun from plain data ready. A low stop bit followed by a line that stays low tests both the framing flag and the rule that the receiver waits for the line to go high. A short low glitch must be rejected at mid-bit, and a long low period must raise break only after the full 12-bit window.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    localparam int unsigned CHAR_MAX = 8;

    typedef struct packed {
        logic [CHAR_MAX-1:0] data;
        logic                par_bad;
        logic                stop_bad;
    } rx_frame_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int unsigned OSR      = 16,
    parameter int unsigned MIN_BITS = 5,
    parameter int unsigned WL_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_i,
    input  logic            tick_i,
    input  logic [WL_W-1:0] wlen_i,
    input  logic            par_en_i,
    input  logic            par_even_i,
    input  logic            par_stick_i,
    output logic            load_o,
    output rx_frame_t       frame_o
);
    localparam int unsigned DW    = CHAR_MAX;
    localparam int unsigned CNT_W = $clog2(OSR);
    localparam int unsigned BW    = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OSR - 1);

    typedef struct packed {
        rx_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [BW-1:0]  bidx;
        logic [DW-1:0]  sh;
        logic           pbit;
        logic           load;
        rx_frame_t      frame;
    } fr_state_t;

    fr_state_t r_d, r_q;

    logic [BW-1:0] nbits;
    logic [BW-1:0] shamt;
    logic [DW-1:0] aligned;
    logic          par_xor;
    logic          par_exp;

    always_comb begin
        nbits   = BW'(MIN_BITS) + BW'(wlen_i);
        shamt   = BW'(DW) - nbits;
        aligned = r_q.sh >> shamt;
        par_xor = ^aligned;
        if (par_stick_i) par_exp = par_even_i;
        else             par_exp = par_even_i ? par_xor : ~par_xor;
    end

    always_comb begin
        r_d      = r_q;
        r_d.load = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (tick_i && !line_i) begin
                    r_d.st  = ST_START;
                    r_d.cnt = '0;
                end
            end
            ST_START: begin
                if (tick_i) begin
                    if (r_q.cnt == HALF_LAST) begin
                        r_d.cnt  = '0;
                        r_d.bidx = '0;
                        r_d.st   = line_i ? ST_IDLE : ST_DATA;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick_i) begin
                    if (r_q.cnt == FULL_LAST) begin
                        r_d.cnt = '0;
                        r_d.sh  = {line_i, r_q.sh[DW-1:1]};
                        if (r_q.bidx == nbits - 1'b1) begin
                            r_d.st = par_en_i ? ST_PAR : ST_STOP;
                        end else begin
                            r_d.bidx = r_q.bidx + 1'b1;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick_i) begin
                    if (r_q.cnt == FULL_LAST) begin
                        r_d.cnt  = '0;
                        r_d.pbit = line_i;
                        r_d.st   = ST_STOP;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick_i) begin
                    if (r_q.cnt == FULL_LAST) begin
                        r_d.cnt            = '0;
                        r_d.load           = 1'b1;
                        r_d.frame.data     = aligned;
                        r_d.frame.par_bad  = par_en_i && (r_q.pbit != par_exp);
                        r_d.frame.stop_bad = !line_i;
                        r_d.st             = line_i ? ST_IDLE : ST_HOLD;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (line_i) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign load_o  = r_q.load;
    assign frame_o = r_q.frame;
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk #(
    parameter int unsigned LIMIT = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic tick_i,
    output logic brk_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM     = CW'(LIMIT);
    localparam logic [CW-1:0] LIM_M1  = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
    } bk_state_t;

    bk_state_t b_d, b_q;

    always_comb begin
        b_d       = b_q;
        b_d.pulse = 1'b0;
        if (line_i) begin
            b_d.cnt = '0;
        end else if (tick_i && (b_q.cnt != LIM)) begin
            b_d.cnt = b_q.cnt + 1'b1;
            if (b_q.cnt == LIM_M1) b_d.pulse = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign brk_o = b_q.pulse;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  rx_frame_t           frame_i,
    input  logic                brk_i,
    input  logic                rd_data_i,
    input  logic                rd_stat_i,
    output logic [CHAR_MAX-1:0] data_o,
    output logic                dr_o,
    output logic                oe_o,
    output logic                pe_o,
    output logic                fe_o,
    output logic                bi_o
);
    typedef struct packed {
        logic [CHAR_MAX-1:0] data;
        logic                dr;
        logic                oe;
        logic                pe;
        logic                fe;
        logic                bi;
    } st_word_t;

    st_word_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.data = frame_i.data;
            s_d.dr   = 1'b1;
        end else if (rd_data_i) begin
            s_d.dr = 1'b0;
        end

        if (load_i && s_q.dr && !rd_data_i) s_d.oe = 1'b1;
        else if (rd_stat_i)                 s_d.oe = 1'b0;

        if (load_i && frame_i.par_bad) s_d.pe = 1'b1;
        else if (rd_stat_i)            s_d.pe = 1'b0;

        if (load_i && frame_i.stop_bad) s_d.fe = 1'b1;
        else if (rd_stat_i)             s_d.fe = 1'b0;

        if (brk_i)          s_d.bi = 1'b1;
        else if (rd_stat_i) s_d.bi = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign data_o = s_q.data;
    assign dr_o   = s_q.dr;
    assign oe_o   = s_q.oe;
    assign pe_o   = s_q.pe;
    assign fe_o   = s_q.fe;
    assign bi_o   = s_q.bi;
endmodule

// File: rtl/uart_lsr_rx.sv
module uart_lsr_rx
    import uart_rx_pkg::*;
#(
    parameter int unsigned OSR       = 16,
    parameter int unsigned SYNC_LEN  = 2,
    parameter int unsigned MIN_BITS  = 5,
    parameter int unsigned FRAME_MAX = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rxd_i,
    input  logic                os_tick_i,
    input  logic [1:0]          wlen_i,
    input  logic                par_en_i,
    input  logic                par_even_i,
    input  logic                par_stick_i,
    input  logic                rd_data_i,
    input  logic                rd_stat_i,
    input  logic                tx_empty_i,
    output logic [CHAR_MAX-1:0] rx_data_o,
    output logic                data_ready_o,
    output logic                overrun_o,
    output logic                parity_err_o,
    output logic                framing_err_o,
    output logic                break_o,
    output logic                both_empty_o
);
    localparam int unsigned BRK_TICKS = OSR * FRAME_MAX;

    logic      line_s;
    logic      frm_load;
    rx_frame_t frm_word;
    logic      brk_pulse;

    uart_rx_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd_i),
        .dout (line_s)
    );

    uart_rx_frame #(.OSR(OSR), .MIN_BITS(MIN_BITS), .WL_W(2)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_s),
        .tick_i     (os_tick_i),
        .wlen_i     (wlen_i),
        .par_en_i   (par_en_i),
        .par_even_i (par_even_i),
        .par_stick_i(par_stick_i),
        .load_o     (frm_load),
        .frame_o    (frm_word)
    );

    uart_rx_brk #(.LIMIT(BRK_TICKS)) u_brk (
        .clk   (clk),
        .rst_n (rst_n),
        .line_i(line_s),
        .tick_i(os_tick_i),
        .brk_o (brk_pulse)
    );

    uart_rx_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (frm_load),
        .frame_i  (frm_word),
        .brk_i    (brk_pulse),
        .rd_data_i(rd_data_i),
        .rd_stat_i(rd_stat_i),
        .data_o   (rx_data_o),
        .dr_o     (data_ready_o),
        .oe_o     (overrun_o),
        .pe_o     (parity_err_o),
        .fe_o     (framing_err_o),
        .bi_o     (break_o)
    );

    assign both_empty_o = tx_empty_i & ~data_ready_o;
endmodule

// File: rtl/uart_lsr_rx_chk.sv
module uart_lsr_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_data_i,
    input logic [7:0] rx_data_o,
    input logic       data_ready_o,
    input logic       overrun_o,
    input logic       parity_err_o,
    input logic       framing_err_o,
    input logic       break_o,
    input logic       both_empty_o,
    input logic       frm_load,
    input logic       brk_pulse
);
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frm_load) |-> $stable(rx_data_o)); // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_data_i) && !$past(frm_load)) |-> !data_ready_o); // R3

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> ($past(frm_load) && $past(data_ready_o))); // R4

    AST_PAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parity_err_o) |-> $past(frm_load)); // R5

    AST_FRM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(framing_err_o) |-> $past(frm_load)); // R6

    AST_BRK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(break_o) |-> $past(brk_pulse)); // R7

    AST_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready_o |-> !both_empty_o); // R8
endmodule

bind uart_lsr_rx uart_lsr_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_data_i    (rd_data_i),
    .rx_data_o    (rx_data_o),
    .data_ready_o (data_ready_o),
    .overrun_o    (overrun_o),
    .parity_err_o (parity_err_o),
    .framing_err_o(framing_err_o),
    .break_o      (break_o),
    .both_empty_o (both_empty_o),
    .frm_load     (frm_load),
    .brk_pulse    (brk_pulse)
);

// File: tb/uart_lsr_rx_tb.sv
module uart_lsr_rx_tb;
    localparam int BITCLK  = 64;
    localparam int BRK_LIM = 192;
    localparam int WD_MAX  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] wlen = 2'd3;
    logic       pen = 1'b0, peven = 1'b0, pstick = 1'b0;
    logic       rd_d = 1'b0, rd_s = 1'b0, txe = 1'b1;
    logic [7:0] rdata;
    logic       dr, oe, pe, fe, bi, be;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_lsr_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .os_tick_i(tick),
        .wlen_i(wlen), .par_en_i(pen), .par_even_i(peven), .par_stick_i(pstick),
        .rd_data_i(rd_d), .rd_stat_i(rd_s), .tx_empty_i(txe),
        .rx_data_o(rdata), .data_ready_o(dr), .overrun_o(oe),
        .parity_err_o(pe), .framing_err_o(fe), .break_o(bi), .both_empty_o(be)
    );

    int tdiv = 0;
    always @(negedge clk) begin
        tick = (tdiv == 3);
        tdiv = (tdiv + 1) % 4;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference: integer state, bits kept in an indexed array.
    bit sy[$];
    int m_st = 0, m_cnt = 0, m_idx = 0, m_bc = 0;
    bit m_bits[8];
    bit m_pbit;
    bit p_ld = 0, p_pb = 0, p_sb = 0, p_bk = 0;
    int p_data = 0;
    int e_data = 0;
    bit e_dr = 0, e_oe = 0, e_pe = 0, e_fe = 0, e_bi = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            sy = '{1'b1, 1'b1};
            m_st = 0; m_cnt = 0; m_idx = 0; m_bc = 0;
            p_ld = 0; p_bk = 0; p_pb = 0; p_sb = 0; p_data = 0;
            e_data = 0; e_dr = 0; e_oe = 0; e_pe = 0; e_fe = 0; e_bi = 0;
        end else begin
            bit s, ld, bk, pb, sb;
            int dat;
            int nb;
            s = sy.pop_front();
            sy.push_back(rxd);
            ld = 0; bk = 0; pb = 0; sb = 0; dat = 0;
            nb = 5 + int'(wlen);
            // status update from the previous cycle's frame result
            if (p_ld && e_dr && !rd_d) e_oe = 1; else if (rd_s) e_oe = 0;
            if (p_ld && p_pb) e_pe = 1; else if (rd_s) e_pe = 0;
            if (p_ld && p_sb) e_fe = 1; else if (rd_s) e_fe = 0;
            if (p_bk) e_bi = 1; else if (rd_s) e_bi = 0;
            if (p_ld) begin e_dr = 1; e_data = p_data; end
            else if (rd_d) e_dr = 0;
            // break window
            if (s) m_bc = 0;
            else if (tick && m_bc != BRK_LIM) begin
                m_bc++;
                if (m_bc == BRK_LIM) bk = 1;
            end
            // frame recovery
            if (m_st == 5) begin
                if (s) m_st = 0;
            end else if (tick) begin
                case (m_st)
                    0: if (!s) begin m_st = 1; m_cnt = 0; end
                    1: if (m_cnt == 7) begin
                           if (s) m_st = 0;
                           else begin
                               m_st = 2; m_cnt = 0; m_idx = 0;
                               foreach (m_bits[i]) m_bits[i] = 0;
                           end
                       end else m_cnt++;
                    2: if (m_cnt == 15) begin
                           m_cnt = 0; m_bits[m_idx] = s;
                           if (m_idx == nb - 1) m_st = pen ? 3 : 4;
                           else m_idx++;
                       end else m_cnt++;
                    3: if (m_cnt == 15) begin m_cnt = 0; m_pbit = s; m_st = 4; end
                       else m_cnt++;
                    default: if (m_cnt == 15) begin
                           bit x;
                           bit want;
                           x = 0;
                           for (int i = 0; i < 8; i++) begin
                               dat += int'(m_bits[i]) << i;
                               x ^= m_bits[i];
                           end
                           want = pstick ? peven : (peven ? x : !x);
                           pb = pen && (m_pbit != want);
                           sb = !s;
                           ld = 1; m_cnt = 0;
                           m_st = s ? 0 : 5;
                       end else m_cnt++;
                endcase
            end
            p_ld = ld; p_bk = bk; p_pb = pb; p_sb = sb;
            if (ld) p_data = dat;
        end
    end

    // every-clock comparison, away from the edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R2 model rx_data", int'(rdata), e_data);
            chk("R3 model data_ready", int'(dr), int'(e_dr));
            chk("R4 model overrun", int'(oe), int'(e_oe));
            chk("R5 model parity_err", int'(pe), int'(e_pe));
            chk("R6 model framing_err", int'(fe), int'(e_fe));
            chk("R7 model break", int'(bi), int'(e_bi));
            chk("R8 model both_empty", int'(be), int'(txe && !e_dr));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WD_MAX && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_MAX);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input bit has_p,
                        input bit pv, input bit stopv);
        rxd = 0; idle(BITCLK);
        for (int i = 0; i < nb; i++) begin rxd = d[i]; idle(BITCLK); end
        if (has_p) begin rxd = pv; idle(BITCLK); end
        rxd = stopv; idle(BITCLK);
        if (stopv) idle(2 * BITCLK);
    endtask

    task automatic rd_data_pulse();
        rd_d = 1; idle(1); rd_d = 0; idle(1);
    endtask

    task automatic rd_stat_pulse();
        rd_s = 1; idle(1); rd_s = 0; idle(1);
    endtask

    function automatic bit par_of(input logic [7:0] d, input int nb);
        bit x = 0;
        for (int i = 0; i < nb; i++) x ^= d[i];
        return x;
    endfunction

    initial begin
        idle(4);
        chk("R9 reset data", int'(rdata), 0);
        chk("R9 reset flags", int'({dr, oe, pe, fe, bi}), 0);
        rst_n = 1;
        idle(8);

        // 8 data bits, no parity
        wlen = 2'd3; pen = 0;
        send(8'hA5, 8, 0, 0, 1);
        chk("R2 8-bit data", int'(rdata), 8'hA5);
        chk("R3 data ready set", int'(dr), 1);
        chk("R8 both_empty low while data held", int'(be), 0);
        rd_data_pulse();
        chk("R3 data ready cleared by read", int'(dr), 0);
        chk("R8 both_empty high after read", int'(be), 1);

        // 5 bits even parity, correct
        wlen = 2'd0; pen = 1; peven = 1; pstick = 0;
        send(8'h1B, 5, 1, par_of(8'h1B, 5), 1);
        chk("R2 5-bit data right-justified", int'(rdata), 8'h1B);
        chk("R5 even parity ok", int'(pe), 0);
        rd_data_pulse();

        // 7 bits odd parity, wrong bit sent
        wlen = 2'd2; peven = 0;
        send(8'h5C, 7, 1, par_of(8'h5C, 7), 1);
        chk("R2 7-bit data", int'(rdata), 8'h5C);
        chk("R5 odd parity mismatch flagged", int'(pe), 1);
        rd_data_pulse();
        rd_stat_pulse();
        chk("R5 parity error cleared by status read", int'(pe), 0);

        // stick parity, even select expects 1
        wlen = 2'd1; pstick = 1; peven = 1;
        send(8'h2A, 6, 1, 1'b1, 1);
        chk("R5 stick parity 1 accepted", int'(pe), 0);
        chk("R2 6-bit data", int'(rdata), 8'h2A);
        rd_data_pulse();
        send(8'h2A, 6, 1, 1'b0, 1);
        chk("R5 stick parity 0 rejected", int'(pe), 1);
        rd_data_pulse();
        rd_stat_pulse();
        peven = 0;
        send(8'h15, 6, 1, 1'b0, 1);
        chk("R5 stick odd-select expects 0", int'(pe), 0);
        rd_data_pulse();

        // overrun
        wlen = 2'd3; pen = 0; pstick = 0;
        send(8'h11, 8, 0, 0, 1);
        send(8'h22, 8, 0, 0, 1);
        chk("R4 overrun on unread data", int'(oe), 1);
        chk("R4 newest character kept", int'(rdata), 8'h22);
        rd_stat_pulse();
        chk("R4 overrun cleared by status read", int'(oe), 0);
        rd_data_pulse();

        // framing error, line stays low afterwards
        send(8'h96, 8, 0, 0, 0);
        rxd = 0; idle(3 * BITCLK);
        rxd = 1; idle(3 * BITCLK);
        chk("R6 framing error flagged", int'(fe), 1);
        chk("R6 data from bad-stop frame", int'(rdata), 8'h96);
        chk("R6 no frame while line held low", int'(oe), 0);
        rd_data_pulse();
        rd_stat_pulse();

        // short glitch rejected at mid-bit
        rxd = 0; idle(16); rxd = 1; idle(3 * BITCLK);
        chk("R1 glitch loads nothing", int'(dr), 0);

        // break
        rxd = 0; idle(700);
        chk("R7 no break before window", int'(bi), 0);
        idle(150);
        chk("R7 break after window", int'(bi), 1);
        rxd = 1; idle(3 * BITCLK);
        rd_data_pulse();
        rd_stat_pulse();
        chk("R7 break cleared by status read", int'(bi), 0);

        // transmitter not empty
        txe = 0; idle(4);
        chk("R8 both_empty follows transmitter", int'(be), 0);
        txe = 1; idle(4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule